// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous static RAM. Its shared data bus never needs an idle turnaround cycle. Reads and writes have the same latency. The command, address, chip enables and byte write enables are captured on a clock edge. The bus then carries that operation's data in the cycle between the first and second enabled edges that follow. A write takes its data from `dataIn` on the second enabled edge. A read presents its word on `dataOut` in that same bus cycle. Because of this, any mix of reads and writes can be issued on consecutive edges.

A burst-advance input replays the previous operation at the next address of a four-beat burst. A clock-enable input freezes every register. The data output enable is separate from the data, so the output can be treated as a tri-state pin. A read issued one edge after a write to the same word would otherwise read the array before that write lands. The block forwards the incoming write bytes to such a read.

Top module: `ltwSram`

## Requirements
- R1: With the chip selected, `adv` low and `rdWrN` low, the edge records a write of `addr`. The word is written from `dataIn` on the second enabled edge after that edge.
- R2: With the chip selected, `adv` low and `rdWrN` high, the edge records a read. `dataOut` carries the word, with `dataOutEn` high when `oeN` is low, from the first enabled edge after the command until the next enabled edge.
- R3: Reads and writes may be issued on every enabled edge, in any order, with no idle cycle, and every read returns the value produced by all earlier writes.
- R4: Lane i (bits 8i+7..8i) is written only when `byteWrN[i]` is low. All four low writes the whole word. All four high writes nothing.
- R5: While `adv` is high, `addr`, the three chip enables and `rdWrN` are ignored. The edge repeats the previous operation kind (read, write or deselect) at the next burst address, and the burst wraps to its start after four beats. `byteWrN` is sampled on every beat.
- R6: The burst address keeps the upper address bits of the start address. For beat k (0..3) with start low bits s, the two low bits are (s+k) mod 4 when `linearOrder` is 1, and s XOR k when it is 0.
- R7: While `clkEnN` is high, edges have no effect: no command, burst step, array write or output change takes place.
- R8: The chip is selected only when `chipEnN`=0, `chipEn`=1 and `chipEnAltN`=0. A deselected command writes nothing and leaves `dataOutEn` low in its data cycle. Operations already issued still complete.
- R9: `dataOutEn` is high only in a read's data cycle with `oeN` low. It is low during write data cycles, deselect cycles and after reset. `oeN` has no effect on writes.
- R10: A read issued on the edge right after a write to the same address returns the stored word, with the lanes enabled by that write replaced by the write's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low; clears the pipeline and burst state |
| clkEnN | input | 1 | Clock enable, active low; high freezes the block |
| chipEnN | input | 1 | Chip enable, active low |
| chipEn | input | 1 | Chip enable, active high |
| chipEnAltN | input | 1 | Second chip enable, active low |
| adv | input | 1 | Burst advance; high steps the burst and ignores the new command |
| rdWrN | input | 1 | Operation: 1 read, 0 write |
| byteWrN | input | LANES | Byte write enables, active low, one per 8-bit lane |
| addr | input | ADDR_W | Word address |
| linearOrder | input | 1 | Burst order: 1 linear, 0 interleaved |
| oeN | input | 1 | Output enable, active low |
| dataIn | input | DATA_W | Write data, sampled two enabled edges after the write command |
| dataOut | output | DATA_W | Read data |
| dataOutEn | output | 1 | High when `dataOut` should drive the bus |

## Verification
The array write of an older write and the array read of a younger read to the same word can happen on the same edge. This is the case R10 covers. The bench provokes it by issuing a write and then a read of that word on the next edge, with full and partial lane enables, in plain streams and in bursts. A reference memory updated from R1 and R4 predicts the merged word, and the bench compares it with `dataOut` in the read's data cycle. A clock-enable stall placed between such a pair must keep both halves of the collision on the same edge. The stalls in the middle of a burst test this.

// File: rtl/ltwSramPkg.sv
package ltwSramPkg;

  localparam int LANE_W = 8;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } opKindT;

  // strobes from control to datapath for the coming edge
  typedef struct packed {
    logic rdEn;    // load read register from stage-1 address
    logic wrEn;    // commit dataIn to stage-2 address
    logic fwdHit;  // read and write target the same word on this edge
  } ctrlStrobesT;

endpackage

// File: rtl/ltwSramCtrl.sv
module ltwSramCtrl
  import ltwSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              chipEnN,
  input  logic              chipEn,
  input  logic              chipEnAltN,
  input  logic              adv,
  input  logic              rdWrN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              linearOrder,
  input  logic              oeN,
  output ctrlStrobesT       strobes,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrLanes,
  output logic              outEn
);

  localparam int BURST_BITS = 2;

  // command stage (after capture edge) and bus stage (after next edge)
  logic              s1Valid, s2Valid;
  opKindT            s1Op, s2Op;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [LANES-1:0]  s1Lanes, s2Lanes;

  // burst state
  logic                  lastSel;
  opKindT                lastOp;
  logic [ADDR_W-1:0]     burstBase;
  logic [BURST_BITS-1:0] burstCnt;

  logic                  stepEn;
  logic                  selNow;
  opKindT                cmdOp;
  logic [BURST_BITS-1:0] cntNext;
  logic [BURST_BITS-1:0] nextLow;
  logic [ADDR_W-1:0]     burstAddr;

  assign stepEn  = !clkEnN;
  assign selNow  = !chipEnN && chipEn && !chipEnAltN;
  assign cmdOp   = rdWrN ? OP_READ : OP_WRITE;
  assign cntNext = burstCnt + 1'b1;

  always_comb begin
    if (linearOrder) nextLow = burstBase[BURST_BITS-1:0] + cntNext;
    else             nextLow = burstBase[BURST_BITS-1:0] ^ cntNext;
  end

  assign burstAddr = {burstBase[ADDR_W-1:BURST_BITS], nextLow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      s2Valid   <= 1'b0;
      s1Op      <= OP_READ;
      s2Op      <= OP_READ;
      s1Addr    <= '0;
      s2Addr    <= '0;
      s1Lanes   <= '0;
      s2Lanes   <= '0;
      lastSel   <= 1'b0;
      lastOp    <= OP_READ;
      burstBase <= '0;
      burstCnt  <= '0;
    end else if (stepEn) begin
      s2Valid <= s1Valid;
      s2Op    <= s1Op;
      s2Addr  <= s1Addr;
      s2Lanes <= s1Lanes;
      s1Lanes <= ~byteWrN;
      if (adv) begin
        burstCnt <= cntNext;
        s1Valid  <= lastSel;
        s1Op     <= lastOp;
        s1Addr   <= burstAddr;
      end else begin
        lastSel   <= selNow;
        lastOp    <= cmdOp;
        burstBase <= addr;
        burstCnt  <= '0;
        s1Valid   <= selNow;
        s1Op      <= cmdOp;
        s1Addr    <= addr;
      end
    end
  end

  always_comb begin
    strobes.rdEn   = stepEn && s1Valid && (s1Op == OP_READ);
    strobes.wrEn   = stepEn && s2Valid && (s2Op == OP_WRITE);
    strobes.fwdHit = strobes.rdEn && strobes.wrEn && (s1Addr == s2Addr);
  end

  assign rdAddr  = s1Addr;
  assign wrAddr  = s2Addr;
  assign wrLanes = s2Lanes;
  assign outEn   = s2Valid && (s2Op == OP_READ) && !oeN;

endmodule

// File: rtl/ltwSramData.sv
module ltwSramData
  import ltwSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobesT               strobes,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [DATA_W/LANE_W-1:0]  wrLanes,
  input  logic [DATA_W-1:0]         dataIn,
  output logic [DATA_W-1:0]         dataOut
);

  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] rdByte;
    logic [LANE_W-1:0] inByte;

    assign inByte = dataIn[g*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (strobes.wrEn && wrLanes[g]) laneMem[wrAddr] <= inByte;
    end

    // the array still holds the old byte on a colliding edge, so bypass it
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             rdByte <= '0;
      else if (strobes.rdEn) rdByte <= (strobes.fwdHit && wrLanes[g]) ? inByte : laneMem[rdAddr];
    end

    assign dataOut[g*LANE_W +: LANE_W] = rdByte;
  end

endmodule

// File: rtl/ltwSram.sv
module ltwSram
  import ltwSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              chipEnN,
  input  logic              chipEn,
  input  logic              chipEnAltN,
  input  logic              adv,
  input  logic              rdWrN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              linearOrder,
  input  logic              oeN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  ctrlStrobesT       strobes;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;
  logic [LANES-1:0]  wrLanes;

  ltwSramCtrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .clkEnN     (clkEnN),
    .chipEnN    (chipEnN),
    .chipEn     (chipEn),
    .chipEnAltN (chipEnAltN),
    .adv        (adv),
    .rdWrN      (rdWrN),
    .byteWrN    (byteWrN),
    .addr       (addr),
    .linearOrder(linearOrder),
    .oeN        (oeN),
    .strobes    (strobes),
    .rdAddr     (rdAddr),
    .wrAddr     (wrAddr),
    .wrLanes    (wrLanes),
    .outEn      (dataOutEn)
  );

  ltwSramData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .rdAddr (rdAddr),
    .wrAddr (wrAddr),
    .wrLanes(wrLanes),
    .dataIn (dataIn),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/ltwSramChecker.sv
module ltwSramChecker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              chipEnN,
  input logic              chipEn,
  input logic              chipEnAltN,
  input logic              adv,
  input logic              rdWrN,
  input logic              oeN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn,
  input logic              rdStrobe,
  input logic              wrStrobe,
  input logic              fwdStrobe
);

  logic selCmd;
  assign selCmd = !chipEnN && chipEn && !chipEnAltN;

  // R1: a write command's bus cycle never drives the output
  a_r1_write_bus_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (selCmd && !rdWrN && !adv && !clkEnN) ##1 !clkEnN |=> !dataOutEn);

  // R2: a read command drives the bus after the next enabled edge
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    (selCmd && rdWrN && !adv && !clkEnN) ##1 !clkEnN |=> (oeN || dataOutEn));

  // R7: a stalled edge leaves the output data unchanged
  a_r7_stall_holds_data: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(dataOut));

  // R8: a deselect command keeps its bus cycle quiet
  a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!selCmd && !adv && !clkEnN) ##1 !clkEnN |=> !dataOutEn);

  // R9: no output drive while write data is being taken
  a_r9_no_drive_on_write: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> !dataOutEn);

  // R10: forwarding only when a read and a write meet on one edge
  a_r10_fwd_needs_pair: assert property (@(posedge clk) disable iff (!rstN)
    fwdStrobe |-> (rdStrobe && wrStrobe && !clkEnN));

endmodule

bind ltwSram ltwSramChecker #(.DATA_W(DATA_W)) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .clkEnN    (clkEnN),
  .chipEnN   (chipEnN),
  .chipEn    (chipEn),
  .chipEnAltN(chipEnAltN),
  .adv       (adv),
  .rdWrN     (rdWrN),
  .oeN       (oeN),
  .dataOut   (dataOut),
  .dataOutEn (dataOutEn),
  .rdStrobe  (strobes.rdEn),
  .wrStrobe  (strobes.wrEn),
  .fwdStrobe (strobes.fwdHit)
);

// File: tb/tb_ltwSram.sv
module tb_ltwSram;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int LANES  = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clkEnN = 1'b0;
  logic              chipEnN = 1'b1;
  logic              chipEn = 1'b1;
  logic              chipEnAltN = 1'b0;
  logic              adv = 1'b0;
  logic              rdWrN = 1'b1;
  logic [LANES-1:0]  byteWrN = '1;
  logic [ADDR_W-1:0] addr = '0;
  logic              linearOrder = 1'b1;
  logic              oeN = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic              dataOutEn;

  ltwSram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .chipEnN(chipEnN), .chipEn(chipEn),
    .chipEnAltN(chipEnAltN), .adv(adv), .rdWrN(rdWrN), .byteWrN(byteWrN), .addr(addr),
    .linearOrder(linearOrder), .oeN(oeN), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state, built from the requirements
  logic [DATA_W-1:0] refMem [DEPTH];
  bit          lastSel = 1'b0, lastRead = 1'b1;
  int          base = 0, cnt = 0;
  bit          p1v = 1'b0, p1r = 1'b0, p2v = 1'b0, p2r = 1'b0;
  int          p1a = 0, p2a = 0;
  logic [3:0]  p1l = '0, p2l = '0;
  string       p1t = "", p2t = "";
  logic [DATA_W-1:0] outVal = '0;
  logic [DATA_W-1:0] dataGen = 32'h1234_5678;

  // scoreboard queues: one entry per driven cycle
  bit                expEnQ[$];
  logic [DATA_W-1:0] expDataQ[$];
  string             expTagQ[$];

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: drives one cycle and pushes what the outputs must show after its edge
  task automatic tick(bit en, bit advI, int ceMode, bit rd, int a, logic [3:0] bw,
                      bit oe, bit lin, string tag);
    @(negedge clk);
    clkEnN      = !en;
    adv         = advI;
    chipEnN     = (ceMode == 1);
    chipEn      = (ceMode != 2);
    chipEnAltN  = (ceMode == 3);
    rdWrN       = rd;
    addr        = ADDR_W'(a);
    byteWrN     = bw;
    oeN         = oe;
    linearOrder = lin;
    dataGen     = dataGen * 32'd1664525 + 32'd1013904223;
    dataIn      = dataGen;
    if (en) begin
      if (p2v && !p2r)
        for (int l = 0; l < LANES; l++)
          if (p2l[l]) refMem[p2a][l*8 +: 8] = dataIn[l*8 +: 8];
      if (p1v && p1r) outVal = refMem[p1a];
      p2v = p1v; p2r = p1r; p2a = p1a; p2l = p1l; p2t = p1t;
      if (advI) begin
        int low;
        cnt = (cnt + 1) % 4;
        low = lin ? ((base % 4) + cnt) % 4 : ((base % 4) ^ cnt);
        p1v = lastSel; p1r = lastRead; p1a = (base & ~3) | low;
      end else begin
        lastSel = (ceMode == 0); lastRead = rd; base = a; cnt = 0;
        p1v = lastSel; p1r = rd; p1a = a;
      end
      p1l = ~bw; p1t = tag;
    end
    expEnQ.push_back(p2v && p2r && !oe);
    expDataQ.push_back(outVal);
    expTagQ.push_back((p2v && p2r) ? p2t : tag);
  endtask

  task automatic wr(int a, logic [3:0] bw, string tag, bit oe = 1'b0);
    tick(1'b1, 1'b0, 0, 1'b0, a, bw, oe, 1'b1, tag);
  endtask

  task automatic rd(int a, string tag, bit lin = 1'b1, bit oe = 1'b0);
    tick(1'b1, 1'b0, 0, 1'b1, a, 4'hF, oe, lin, tag);
  endtask

  task automatic idle(string tag, int ceMode = 1);
    tick(1'b1, 1'b0, ceMode, 1'b1, 0, 4'hF, 1'b0, 1'b1, tag);
  endtask

  // burst beat with junk on the ignored pins
  task automatic beat(bit lin, logic [3:0] bw, string tag, int junk);
    tick(1'b1, 1'b1, 1 + (junk % 3), junk[0], (junk * 7) % DEPTH, bw, 1'b0, lin, tag);
  endtask

  task automatic stall(string tag);
    tick(1'b0, 1'b0, 0, 1'b0, 13, 4'h0, 1'b0, 1'b1, tag);
  endtask

  // monitor: compares outputs after each driven edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expEnQ.size() > 0) begin
        bit                expEn;
        logic [DATA_W-1:0] expData;
        string             tag;
        expEn   = expEnQ.pop_front();
        expData = expDataQ.pop_front();
        tag     = expTagQ.pop_front();
        checks++;
        if (dataOutEn !== expEn) begin
          errors++;
          $display("FAIL %s dataOutEn actual %b expected %b at %0t", tag, dataOutEn, expEn, $time);
        end else if (expEn) begin
          checks++;
          if (dataOut !== expData) begin
            errors++;
            $display("FAIL %s dataOut actual %h expected %h at %0t", tag, dataOut, expData, $time);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: R9
    checks++;
    if (dataOutEn !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset dataOutEn actual %b expected 0", dataOutEn);
    end
    rstN = 1'b1;

    // R1: fill the array with back-to-back full writes
    for (int i = 0; i < DEPTH; i++) wr(i, 4'h0, "R1");
    // R2: back-to-back reads straight after the writes
    for (int i = 0; i < 16; i++) rd(i, "R2");

    // R3 / R10: alternating streams, read right behind a write to the same word
    for (int i = 0; i < 8; i++) begin
      wr(20 + i, 4'h0, "R3");
      rd(20 + i, "R10");
      rd(i, "R3");
    end

    // R4: partial lane writes, forwarded and from the array
    wr(30, 4'b0101, "R4");
    rd(30, "R10");
    wr(31, 4'b1110, "R4");
    idle("R4");
    rd(31, "R4");
    wr(32, 4'b1111, "R4");
    rd(32, "R4");
    idle("R4");
    rd(32, "R4");

    // R6: linear burst from low bits 1, then wrap (R5)
    rd(5, "R6", 1'b1);
    for (int k = 1; k < 4; k++) beat(1'b1, 4'hF, "R6", k);
    beat(1'b1, 4'hF, "R5", 4);
    // R6: interleaved burst from low bits 2
    rd(6, "R6", 1'b0);
    for (int k = 1; k < 4; k++) beat(1'b0, 4'hF, "R6", k + 10);
    // R5: interleaved write burst with per-beat lanes, then linear read burst
    wr(41, 4'h0, "R5");
    beat(1'b0, 4'b0011, "R5", 5);
    beat(1'b0, 4'b1100, "R5", 6);
    beat(1'b0, 4'h0, "R5", 7);
    rd(40, "R5", 1'b1);
    for (int k = 1; k < 4; k++) beat(1'b1, 4'hF, "R5", k + 20);

    // R7: stalls inside write and read bursts and between a colliding pair
    wr(50, 4'h0, "R7");
    stall("R7");
    stall("R7");
    beat(1'b1, 4'h0, "R7", 8);
    stall("R7");
    beat(1'b1, 4'b0110, "R7", 9);
    rd(51, "R7");
    stall("R7");
    stall("R7");
    beat(1'b1, 4'hF, "R7", 2);
    stall("R7");
    beat(1'b1, 4'hF, "R7", 3);
    beat(1'b1, 4'hF, "R7", 4);
    wr(12, 4'b1010, "R7");
    stall("R7");
    rd(12, "R10");
    idle("R7");

    // R8: deselected writes via each enable, burst after a deselect, pending read
    tick(1'b1, 1'b0, 1, 1'b0, 0, 4'h0, 1'b0, 1'b1, "R8");
    tick(1'b1, 1'b0, 2, 1'b0, 1, 4'h0, 1'b0, 1'b1, "R8");
    tick(1'b1, 1'b0, 3, 1'b0, 2, 4'h0, 1'b0, 1'b1, "R8");
    tick(1'b1, 1'b1, 0, 1'b0, 3, 4'h0, 1'b0, 1'b1, "R8");
    rd(3, "R8");
    idle("R8", 2);
    idle("R8", 3);
    for (int i = 0; i < 4; i++) rd(i, "R8");

    // R9: output enable off on a read, write with output enable off
    rd(4, "R9", 1'b1, 1'b1);
    wr(9, 4'h0, "R9", 1'b1);
    idle("R9");
    rd(9, "R9");
    rd(4, "R9");

    // final readback of the whole array
    idle("R3");
    for (int i = 0; i < DEPTH; i++) rd(i, "R3");
    idle("R3");
    idle("R3");
    idle("R3");
    @(negedge clk);
    done = 1'b1;
    finishRun();
  end

endmodule